// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the timing skeleton of a progressive video raster: horizontal sync, vertical sync, a data-enable strobe and the column/row coordinate of the current active pixel. Every line runs through four parts in a fixed order: the active pixels, the front porch, the sync pulse and the back porch. Every frame runs through the same four parts counted in lines. The lengths of all parts, and the polarity of each sync output, come from a small register file written over a simple synchronous write port and read back over a combinational read port.

The timing registers are double-buffered. Software writes into a shadow set. While the generator runs, the set that drives the counters is refreshed from the shadow set only on the last clock of a frame. That same one-clock strobe is offered as `frame_end` and latches a frame interrupt. The interrupt has an enable, a masked status and a write-one-to-clear register. A control register starts and stops the generator, turns on gating of the pixel data by data-enable, and holds an output pixel-format code that is driven to a port unchanged.

Top module: `rtg_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. `de`, `hsync`, `vsync`, `frame_end`, `irq` and `fmt_out` are 0, and `pix_out` equals `pix_in`.
- R2: A line has width W = SIZE[11:0]+1 active clocks, then HPORCH[11:0] front-porch clocks, then HSYNC+1 sync clocks, then HPORCH[27:16] back-porch clocks. The raw horizontal sync is asserted only during the sync part.
- R3: A frame has height SIZE[27:16]+1 active lines, then VPORCH[11:0] front-porch lines, then VSYNC+1 sync lines, then VPORCH[27:16] back-porch lines. The raw vertical sync is asserted for every clock of the sync lines.
- R4: The vertical sync field (VSYNC, address 3) is 4 bits wide. A write of a value above 14 stores 14, so a vertical sync pulse never exceeds 15 lines.
- R5: `de` is high only on active pixels of active lines. During `de`, `pix_x`/`pix_y` give the column and row counted from 0; otherwise both are 0.
- R6: POL bit 0 makes `hsync` active-low and POL bit 1 makes `vsync` active-low. When a flag is clear, that output is active-high.
- R7: `frame_end` is a one-clock pulse on the last clock of the last line of each frame, and only while the generator is enabled.
- R8: While enabled, writes to HPORCH, HSYNC, VPORCH, VSYNC, SIZE and POL take effect from the first clock of the frame after the next `frame_end`. While disabled, they take effect at once.
- R9: `frame_end` sets a pending flag. `irq` and IRQ_STAT (address 8) bit 0 show that flag ANDed with IRQ_EN (address 7) bit 0. Writing 1 to bit 0 of IRQ_CLR (address 9) clears the flag, and a simultaneous `frame_end` wins.
- R10: CTRL (address 6) bit 0 enables the generator. With it clear, the counters sit at the first pixel, `de` and `frame_end` are low, the syncs sit at their inactive level, and enabling starts a frame from pixel (0,0). CTRL[6:4] drives `fmt_out`.
- R11: With CTRL bit 1 set, `pix_out` equals `pix_in` while `de` is high and 0 otherwise. With it clear, `pix_out` equals `pix_in` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pix_in | input | PIX_W | Incoming pixel data |
| pix_out | output | PIX_W | Pixel data after optional data-enable gating |
| de | output | 1 | Data-enable, high on active pixels |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| pix_x | output | 12 | Active column, 0 outside data-enable |
| pix_y | output | 12 | Active row, 0 outside data-enable |
| frame_end | output | 1 | One-clock end-of-frame strobe |
| irq | output | 1 | Masked frame interrupt |
| fmt_out | output | FMT_W | Output pixel-format code from CTRL |

## Verification
The embedded properties assume that the programmed active width and height fit the 12-bit coordinate fields. They also assume that a line is at least two clocks long, which the minus-one encoding of width and sync guarantees, so a frame-end pulse can never be followed directly by another. A further assumption is that the software changes timing only through the register port, so the counters never see a shorter line in the middle of a frame. The stimulus keeps within these limits. It uses small modes of a few dozen to a hundred clocks per frame, and it programmes each new mode either while the generator is stopped or through the shadow set during a running frame. Zero-length porches on both axes, and a vertical sync clamped at its 15-line ceiling, are covered because they sit at the edges of the boundary arithmetic.

// File: rtl/rtg_pkg.sv
// Package: shared widths, register addresses and the timing-set record
// for the raster timing generator. Assumes 12-bit counters fit all modes.
package rtg_pkg;
    parameter int RTG_CW    = 12;  // width of every porch, sync and size field
    parameter int RTG_VSW_W = 4;   // width of the vertical sync field
    parameter int RTG_AW    = 4;   // register address width
    parameter int RTG_DW    = 32;  // register data width
    parameter int RTG_HI    = 16;  // LSB of the upper field in packed words

    typedef enum logic [RTG_AW-1:0] {
        A_HPORCH   = 4'd0,
        A_HSYNC    = 4'd1,
        A_VPORCH   = 4'd2,
        A_VSYNC    = 4'd3,
        A_SIZE     = 4'd4,
        A_POL      = 4'd5,
        A_CTRL     = 4'd6,
        A_IRQ_EN   = 4'd7,
        A_IRQ_STAT = 4'd8,
        A_IRQ_CLR  = 4'd9
    } rtg_addr_e;

    typedef struct packed {
        logic [RTG_CW-1:0]    h_fp;
        logic [RTG_CW-1:0]    h_bp;
        logic [RTG_CW-1:0]    h_sw_m1;
        logic [RTG_CW-1:0]    h_act_m1;
        logic [RTG_CW-1:0]    v_fp;
        logic [RTG_CW-1:0]    v_bp;
        logic [RTG_VSW_W-1:0] v_sw_m1;
        logic [RTG_CW-1:0]    v_act_m1;
        logic                 h_neg;
        logic                 v_neg;
    } rtg_timing_t;
endpackage

// File: rtl/rtg_axis.sv
// Module: one timing axis (pixels of a line or lines of a frame).
// Counts a position through active, front porch, sync and back porch and
// flags the region it is in. Zero-length porches are allowed. Assumes the
// limits only change while the position is 0 (at a frame boundary).
module rtg_axis
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,        // generator enabled
    input  logic              step,       // advance by one position
    input  logic [RTG_CW-1:0] act_m1,     // active length minus one
    input  logic [RTG_CW-1:0] fp,         // front porch length
    input  logic [RTG_CW-1:0] sw_m1,      // sync length minus one
    input  logic [RTG_CW-1:0] bp,         // back porch length
    output logic [RTG_CW+1:0] pos,        // current position
    output logic              in_act,
    output logic              in_sync,
    output logic              last        // position is the final one
);
    localparam int PW = RTG_CW + 2;

    logic [PW-1:0] act_end, fp_end, sync_end, total_m1;

    // Region boundaries derived from the current limits.
    always_comb begin : p_bounds
        act_end  = PW'(act_m1) + PW'(1);
        fp_end   = act_end + PW'(fp);
        sync_end = fp_end + PW'(sw_m1) + PW'(1);
        total_m1 = sync_end + PW'(bp) - PW'(1);
    end

    // Position counter: held at 0 when stopped, wraps after the last slot.
    always_ff @(posedge clk) begin : p_pos
        if (!rst_n || !run) begin
            pos <= '0;
        end else if (step) begin
            pos <= last ? '0 : pos + PW'(1);
        end
    end

    assign last    = (pos == total_m1);
    assign in_act  = (pos < act_end);
    assign in_sync = (pos >= fp_end) && (pos < sync_end);

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pos <= total_m1)); // R2

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pos == '0)); // R10
endmodule

// File: rtl/rtg_regs.sv
// Module: register file of the timing generator. Holds the shadow and
// active timing sets, control bits and the frame interrupt. The active set
// follows the shadow set while stopped and is refreshed only on the
// frame-end strobe while running. Reads are combinational.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int FMT_W   = 3,
    parameter int FMT_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RTG_AW-1:0] wr_addr,
    input  logic [RTG_DW-1:0] wr_data,
    input  logic [RTG_AW-1:0] rd_addr,
    output logic [RTG_DW-1:0] rd_data,
    input  logic              frame_end,
    output rtg_timing_t       act,
    output logic              gen_en,
    output logic              gate_en,
    output logic [FMT_W-1:0]  fmt,
    output logic              irq
);
    localparam logic [RTG_VSW_W-1:0] VSW_MAX = RTG_VSW_W'((2 ** RTG_VSW_W) - 2);
    localparam logic [RTG_CW-1:0]    VSW_LIM = RTG_CW'(VSW_MAX);

    rtg_timing_t sh;
    logic        irq_en, irq_raw, clr_hit;

    assign clr_hit = wr_en && (wr_addr == A_IRQ_CLR) && wr_data[0];

    // Capture software writes into the shadow set and control bits.
    always_ff @(posedge clk) begin : p_shadow
        if (!rst_n) begin
            sh      <= '0;
            gen_en  <= 1'b0;
            gate_en <= 1'b0;
            fmt     <= '0;
            irq_en  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_HPORCH: begin
                    sh.h_bp <= wr_data[RTG_HI +: RTG_CW];
                    sh.h_fp <= wr_data[0 +: RTG_CW];
                end
                A_HSYNC:  sh.h_sw_m1 <= wr_data[0 +: RTG_CW];
                A_VPORCH: begin
                    sh.v_bp <= wr_data[RTG_HI +: RTG_CW];
                    sh.v_fp <= wr_data[0 +: RTG_CW];
                end
                A_VSYNC:  sh.v_sw_m1 <= (wr_data[0 +: RTG_CW] > VSW_LIM) ?
                                        VSW_MAX : wr_data[0 +: RTG_VSW_W];
                A_SIZE: begin
                    sh.v_act_m1 <= wr_data[RTG_HI +: RTG_CW];
                    sh.h_act_m1 <= wr_data[0 +: RTG_CW];
                end
                A_POL: begin
                    sh.h_neg <= wr_data[0];
                    sh.v_neg <= wr_data[1];
                end
                A_CTRL: begin
                    gen_en  <= wr_data[0];
                    gate_en <= wr_data[1];
                    fmt     <= wr_data[FMT_LSB +: FMT_W];
                end
                A_IRQ_EN: irq_en <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Active set: follows the shadow while stopped, else only at frame end.
    always_ff @(posedge clk) begin : p_active
        if (!rst_n) begin
            act <= '0;
        end else if (!gen_en || frame_end) begin
            act <= sh;
        end
    end

    // Pending frame flag: set by the strobe, cleared by a write of one.
    always_ff @(posedge clk) begin : p_irq
        if (!rst_n) begin
            irq_raw <= 1'b0;
        end else if (frame_end) begin
            irq_raw <= 1'b1;
        end else if (clr_hit) begin
            irq_raw <= 1'b0;
        end
    end

    assign irq = irq_raw && irq_en;

    // Read multiplexer over the shadow set, control and interrupt state.
    always_comb begin : p_read
        rd_data = '0;
        case (rd_addr)
            A_HPORCH: begin
                rd_data[RTG_HI +: RTG_CW] = sh.h_bp;
                rd_data[0 +: RTG_CW]      = sh.h_fp;
            end
            A_HSYNC:  rd_data[0 +: RTG_CW]    = sh.h_sw_m1;
            A_VPORCH: begin
                rd_data[RTG_HI +: RTG_CW] = sh.v_bp;
                rd_data[0 +: RTG_CW]      = sh.v_fp;
            end
            A_VSYNC:  rd_data[0 +: RTG_VSW_W] = sh.v_sw_m1;
            A_SIZE: begin
                rd_data[RTG_HI +: RTG_CW] = sh.v_act_m1;
                rd_data[0 +: RTG_CW]      = sh.h_act_m1;
            end
            A_POL:    rd_data[1:0] = {sh.v_neg, sh.h_neg};
            A_CTRL: begin
                rd_data[0]                 = gen_en;
                rd_data[1]                 = gate_en;
                rd_data[FMT_LSB +: FMT_W]  = fmt;
            end
            A_IRQ_EN:   rd_data[0] = irq_en;
            A_IRQ_STAT: rd_data[0] = irq_raw && irq_en;
            default: ;
        endcase
    end

    AST_VSW_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        sh.v_sw_m1 <= VSW_MAX); // R4

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !frame_end) |=> $stable(act)); // R8

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !frame_end) |=> !irq_raw); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> irq_raw); // R9
endmodule

// File: rtl/rtg_top.sv
// Module: raster timing generator top. Joins the register file with a
// pixel axis and a line axis, applies polarity, builds data-enable and
// coordinates, and gates pixel data. Assumes one pixel per clock.
module rtg_top
    import rtg_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int FMT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RTG_AW-1:0] wr_addr,
    input  logic [RTG_DW-1:0] wr_data,
    input  logic [RTG_AW-1:0] rd_addr,
    output logic [RTG_DW-1:0] rd_data,
    input  logic [PIX_W-1:0]  pix_in,
    output logic [PIX_W-1:0]  pix_out,
    output logic              de,
    output logic              hsync,
    output logic              vsync,
    output logic [RTG_CW-1:0] pix_x,
    output logic [RTG_CW-1:0] pix_y,
    output logic              frame_end,
    output logic              irq,
    output logic [FMT_W-1:0]  fmt_out
);
    rtg_timing_t       act;
    logic              gen_en, gate_en;
    logic [RTG_CW+1:0] h_pos, v_pos;
    logic              h_act, h_sync, h_last;
    logic              v_act, v_sync, v_last;
    logic [RTG_CW-1:0] v_sw_ext;

    assign v_sw_ext = RTG_CW'(act.v_sw_m1);

    rtg_regs #(.FMT_W(FMT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .frame_end (frame_end),
        .act       (act),
        .gen_en    (gen_en),
        .gate_en   (gate_en),
        .fmt       (fmt_out),
        .irq       (irq)
    );

    rtg_axis u_haxis (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gen_en),
        .step    (1'b1),
        .act_m1  (act.h_act_m1),
        .fp      (act.h_fp),
        .sw_m1   (act.h_sw_m1),
        .bp      (act.h_bp),
        .pos     (h_pos),
        .in_act  (h_act),
        .in_sync (h_sync),
        .last    (h_last)
    );

    rtg_axis u_vaxis (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gen_en),
        .step    (h_last),
        .act_m1  (act.v_act_m1),
        .fp      (act.v_fp),
        .sw_m1   (v_sw_ext),
        .bp      (act.v_bp),
        .pos     (v_pos),
        .in_act  (v_act),
        .in_sync (v_sync),
        .last    (v_last)
    );

    // Raster outputs: enable-qualified regions, polarity, coordinates, gating.
    always_comb begin : p_outputs
        de        = gen_en && h_act && v_act;
        frame_end = gen_en && h_last && v_last;
        hsync     = (gen_en && h_sync) ^ act.h_neg;
        vsync     = (gen_en && v_sync) ^ act.v_neg;
        pix_x     = de ? h_pos[RTG_CW-1:0] : '0;
        pix_y     = de ? v_pos[RTG_CW-1:0] : '0;
        pix_out   = (gate_en && !de) ? '0 : pix_in;
    end

    AST_FE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end); // R7

    AST_DE_NOT_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> !(h_sync || v_sync)); // R5

    AST_RESTART_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (h_pos == '0 && v_pos == '0)); // R10
endmodule

// File: tb/rtg_top_bench.sv
// Scoreboard bench: a driver task queues the expected raster, a monitor
// pops one item per clock at the falling edge and compares.
module rtg_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [23:0] PIX = 24'h5A3C96;

    typedef struct {
        logic        de, hs, vs, fe;
        int          x, y;
        logic [23:0] pix;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [23:0] pix_in = PIX;
    logic [23:0] pix_out;
    logic        de, hsync, vsync, frame_end, irq;
    logic [11:0] pix_x, pix_y;
    logic [2:0]  fmt_out;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string tag = "";
    exp_t  sbq[$];

    rtg_top u_rtg_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_in(pix_in), .pix_out(pix_out), .de(de), .hsync(hsync),
        .vsync(vsync), .pix_x(pix_x), .pix_y(pix_y), .frame_end(frame_end),
        .irq(irq), .fmt_out(fmt_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, got, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic program_mode(input int w, h, hfp, hs, hbp, vfp, vs, vbp,
                                input bit hneg, vneg);
        reg_wr(4'd0, (32'(hbp) << 16) | 32'(hfp));
        reg_wr(4'd1, 32'(hs - 1));
        reg_wr(4'd2, (32'(vbp) << 16) | 32'(vfp));
        reg_wr(4'd3, 32'(vs - 1));
        reg_wr(4'd4, (32'(h - 1) << 16) | 32'(w - 1));
        reg_wr(4'd5, {30'd0, vneg, hneg});
    endtask

    // Driver side: queue the expected raster of nf frames from the rules.
    task automatic push_frames(input int w, h, hfp, hs, hbp, vfp, vs, vbp,
                               input bit hneg, vneg, gate, input int nf);
        int htot = w + hfp + hs + hbp;
        int vtot = h + vfp + vs + vbp;
        for (int f = 0; f < nf; f++) begin
            for (int v = 0; v < vtot; v++) begin
                for (int p = 0; p < htot; p++) begin
                    exp_t e;
                    e.de  = (p < w) && (v < h);
                    e.hs  = ((p >= w + hfp) && (p < w + hfp + hs)) ^ hneg;
                    e.vs  = ((v >= h + vfp) && (v < h + vfp + vs)) ^ vneg;
                    e.fe  = (p == htot - 1) && (v == vtot - 1);
                    e.x   = e.de ? p : 0;
                    e.y   = e.de ? v : 0;
                    e.pix = (gate && !e.de) ? 24'd0 : PIX;
                    sbq.push_back(e);
                end
            end
        end
    endtask

    // Monitor side: compare one queued item per clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk({"R5 de ", tag}, 32'(de), 32'(e.de));
            chk({"R2 R6 hsync ", tag}, 32'(hsync), 32'(e.hs));
            chk({"R3 R6 vsync ", tag}, 32'(vsync), 32'(e.vs));
            chk({"R7 frame_end ", tag}, 32'(frame_end), 32'(e.fe));
            chk({"R5 pix_x ", tag}, 32'(pix_x), 32'(e.x));
            chk({"R5 pix_y ", tag}, 32'(pix_y), 32'(e.y));
            chk({"R11 pix_out ", tag}, 32'(pix_out), 32'(e.pix));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            report();
        end
    end

    initial begin
        logic [31:0] d;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 de", 32'(de), 0);
        chk("R1 hsync", 32'(hsync), 0);
        chk("R1 vsync", 32'(vsync), 0);
        chk("R1 frame_end", 32'(frame_end), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fmt_out", 32'(fmt_out), 0);
        chk("R1 pix_out", 32'(pix_out), 32'(PIX));
        reg_rd(4'd0, d); chk("R1 HPORCH", d, 0);
        reg_rd(4'd4, d); chk("R1 SIZE", d, 0);
        reg_rd(4'd6, d); chk("R1 CTRL", d, 0);

        // Mode A, gated data, two frames. R2 R3 R5 R7 R10 R11
        tag = "modeA";
        program_mode(4, 3, 1, 2, 1, 1, 2, 1, 1'b0, 1'b0);
        reg_wr(4'd6, 32'h0000_0053); // enable, gate, format 5
        push_frames(4, 3, 1, 2, 1, 1, 2, 1, 1'b0, 1'b0, 1'b1, 2);
        chk("R10 fmt_out", 32'(fmt_out), 5);
        wait (sbq.size() == 0);
        @(posedge clk); #1;

        // R10: stop, outputs idle
        reg_wr(4'd6, 32'h0);
        @(negedge clk);
        chk("R10 de off", 32'(de), 0);
        chk("R10 frame_end off", 32'(frame_end), 0);
        chk("R10 pix_x off", 32'(pix_x), 0);
        chk("R10 fmt_out off", 32'(fmt_out), 0);

        // R8: shadow write during a running frame applies one frame later.
        // Mode B has zero horizontal back porch and zero vertical front porch.
        tag = "R8 shadow";
        reg_wr(4'd6, 32'h0000_0001); // enable, no gate
        push_frames(4, 3, 1, 2, 1, 1, 2, 1, 1'b0, 1'b0, 1'b0, 1);
        push_frames(5, 2, 2, 1, 0, 0, 3, 2, 1'b1, 1'b1, 1'b0, 2);
        repeat (3) @(posedge clk);
        program_mode(5, 2, 2, 1, 0, 0, 3, 2, 1'b1, 1'b1);
        wait (sbq.size() == 0);
        @(posedge clk); #1;

        // R9: pending flag is masked until enabled
        tag = "";
        @(negedge clk);
        chk("R9 irq masked", 32'(irq), 0);
        reg_rd(4'd8, d); chk("R9 stat masked", d, 0);
        reg_wr(4'd6, 32'h0);
        @(negedge clk);
        chk("R6 R10 hsync idle neg", 32'(hsync), 1);
        chk("R6 R10 vsync idle neg", 32'(vsync), 1);
        reg_wr(4'd7, 32'h1);
        @(negedge clk);
        chk("R9 irq enabled", 32'(irq), 1);
        reg_rd(4'd8, d); chk("R9 stat enabled", d, 1);
        reg_wr(4'd9, 32'h0);
        @(negedge clk);
        chk("R9 clear with zero ignored", 32'(irq), 1);
        reg_wr(4'd9, 32'h1);
        @(negedge clk);
        chk("R9 irq cleared", 32'(irq), 0);
        reg_rd(4'd8, d); chk("R9 stat cleared", d, 0);

        // R4: vertical sync saturates at 15 lines
        reg_wr(4'd3, 32'd9);
        reg_rd(4'd3, d); chk("R4 vsync in range", d, 9);
        reg_wr(4'd3, 32'd200);
        reg_rd(4'd3, d); chk("R4 vsync saturated", d, 14);
        tag = "R4 long vsync";
        program_mode(3, 2, 0, 1, 0, 1, 31, 0, 1'b0, 1'b0);
        reg_rd(4'd3, d); chk("R4 vsync saturated again", d, 14);
        reg_wr(4'd6, 32'h0000_0003);
        push_frames(3, 2, 0, 1, 0, 1, 15, 0, 1'b0, 1'b0, 1'b1, 1);
        wait (sbq.size() == 0);
        @(negedge clk);
        chk("R9 irq after new frame", 32'(irq), 1);
        report();
    end
endmodule